// File: doc/BRIEF.md
# Multi-Word Micro-Operation Sequencer

This block sits between decode and issue in an in-order core whose register file has two read ports and one write port. Some instructions touch more registers than one pass through the pipeline can serve. The block takes one decoded instruction at a time and breaks it into a stream of micro-operations. It sends out one micro-operation per cycle. Each one carries a register number, a kind marker that tells the datapath what the step does, and a flag on the final step.

Instructions are offered with a valid/ready handshake. The block accepts a new instruction only when it is idle, or in the cycle in which the last micro-operation of the current instruction leaves. This allows back-to-back issue with no bubble. While a sequence is in progress, `busy` holds the issue stage.

The long operations need extra time before their steps appear. A divide first waits `DIV_WAIT` cycles, and the slow multiply first waits `MUL_WAIT` cycles. During those cycles the block is busy but sends out no micro-operation.

Top module: `uop_sequencer`

## Requirements
- R1: After reset, `busy` is 0, `uop_valid` is 0 and `in_ready` is 1.
- R2: An instruction is taken at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when the block is idle, or when a micro-operation with `uop_last`=1 is being sent out. The first micro-operation of a taken instruction appears in the next cycle. `busy` is 1 from then until the cycle after the last micro-operation, unless a new instruction is taken in that cycle.
- R3: Load-multiple uses class 1 and store-multiple uses class 2. Each sends one micro-operation of kind DATA (code 1) per set bit of `in_reglist`, in ascending bit order, on consecutive cycles. `uop_reg` is the bit index.
- R4: For class 1 or 2 with a non-empty list and `in_wb`=1, one extra micro-operation follows the data steps. It has kind BASE (code 2), `uop_reg`=`in_rs` and `uop_last`=1. With `in_wb`=0, the last data step carries `uop_last`.
- R5: For class 1 or 2 with an empty list, the block sends a single micro-operation of kind NOP (code 0) with `uop_reg`=0 and `uop_last`=1. `in_wb` is ignored in this case.
- R6: Double-word load (class 3), double-word store (class 4) and double-word move (class 5) each send two DATA micro-operations. The first is the even register of the pair holding `in_rt`, and the second is the odd register, with `uop_last` set.
- R7: Post-increment load (class 6) sends two micro-operations. The first is DATA with `in_rt`. The second is BASE with `in_rs` and is last.
- R8: Register-offset store (class 7) sends two micro-operations. The first is EXEC (code 3) with `in_rs`, for address generation. The second is DATA with `in_rt`, the store data, and is last.
- R9: Multiply-accumulate (class 8) sends two micro-operations. The first is EXEC with `in_rs`, the multiply step. The second is DATA with `in_rt`, the accumulate read, and is last.
- R10: Divide (class 9) keeps `busy`=1 with `uop_valid`=0 and `in_ready`=0 for `DIV_WAIT` cycles. It then sends DATA with `in_rt` (the quotient), followed by DATA with `in_rs` (the remainder), which is last.
- R11: Slow multiply (class 10) keeps `busy`=1 with no micro-operation for `MUL_WAIT` cycles. It then sends one EXEC micro-operation with `in_rt`, which is last.
- R12: Class 0 (single) and the codes 11 to 15 send one DATA micro-operation with `in_rt` and `uop_last`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction will be taken at this edge |
| in_class | input | 4 | Instruction class code |
| in_rt | input | RW (5) | Primary register |
| in_rs | input | RW (5) | Secondary or base register |
| in_reglist | input | NREG (32) | Register list for the multiple classes |
| in_wb | input | 1 | Base register write-back for the multiple classes |
| uop_valid | output | 1 | A micro-operation is sent this cycle |
| uop_reg | output | RW (5) | Register of the micro-operation |
| uop_kind | output | 2 | 0 NOP, 1 DATA, 2 BASE, 3 EXEC |
| uop_last | output | 1 | Final micro-operation of the instruction |
| busy | output | 1 | Issue stage held by a sequence in progress |

## Verification
Register lists are tried with sparse bits, with the two end bits alone, with all 32 bits set and with no bits set. These cases separate the ascending walk, the placement of the last flag, the base step added by write-back, and the no-op fallback. Each two-step class is used with odd and even primary registers, so that any swap of the even and odd registers, or of the two register fields, shows up. The instructions are offered back to back, with `in_valid` held high while the block is busy. This exposes early acceptance, a lost instruction after a last step, and a wrong wait length before the divide and slow multiply steps.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

   typedef enum logic [3:0] {
      CLS_SINGLE = 4'd0,
      CLS_LDM    = 4'd1,
      CLS_STM    = 4'd2,
      CLS_LDD    = 4'd3,
      CLS_STD    = 4'd4,
      CLS_MOVD   = 4'd5,
      CLS_LDPI   = 4'd6,
      CLS_STRR   = 4'd7,
      CLS_MAC    = 4'd8,
      CLS_DIV    = 4'd9,
      CLS_MULS   = 4'd10
   } cls_e;

   typedef enum logic [1:0] {
      K_NOP  = 2'd0,
      K_DATA = 2'd1,
      K_BASE = 2'd2,
      K_EXEC = 2'd3
   } kind_e;

   function automatic cls_e decode_cls(input logic [3:0] code);
      case (code)
         4'd1:    return CLS_LDM;
         4'd2:    return CLS_STM;
         4'd3:    return CLS_LDD;
         4'd4:    return CLS_STD;
         4'd5:    return CLS_MOVD;
         4'd6:    return CLS_LDPI;
         4'd7:    return CLS_STRR;
         4'd8:    return CLS_MAC;
         4'd9:    return CLS_DIV;
         4'd10:   return CLS_MULS;
         default: return CLS_SINGLE;
      endcase
   endfunction

endpackage

// File: rtl/uop_lowbit_pick.sv
module uop_lowbit_pick #(
   parameter int NREG = 32,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREG-1:0] mask,
   output logic [NREG-1:0] onehot,
   output logic [IDXW-1:0] idx,
   output logic            any,
   output logic            single
);

   logic [NREG:0] seen;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NREG; g++) begin : g_chain
      assign seen[g+1]  = seen[g] | mask[g];
      assign onehot[g]  = mask[g] & ~seen[g];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (onehot[i]) idx = IDXW'(i);
      end
   end

   assign any    = seen[NREG];
   assign single = any && ((mask & ~onehot) == '0);

   // R3
   pick_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (mask[idx] && ((mask & ((NREG'(1) << idx) - NREG'(1))) == '0)));

endmodule

// File: rtl/uop_wait_timer.sv
module uop_wait_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R10
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
   import uop_seq_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int DIV_WAIT = 36,
   parameter int MUL_WAIT = 16,
   localparam int RW       = $clog2(NREG),
   localparam int WAIT_MAX = (DIV_WAIT > MUL_WAIT) ? DIV_WAIT : MUL_WAIT,
   localparam int CW       = $clog2(WAIT_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [3:0]      in_class,
   input  logic [RW-1:0]   in_rt,
   input  logic [RW-1:0]   in_rs,
   input  logic [NREG-1:0] in_reglist,
   input  logic            in_wb,
   output logic            uop_valid,
   output logic [RW-1:0]   uop_reg,
   output logic [1:0]      uop_kind,
   output logic            uop_last,
   output logic            busy
);

   if (NREG < 4 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 4");
   end
   if (DIV_WAIT < 1 || MUL_WAIT < 1) begin : g_bad_wait
      $error("wait lengths must be at least 1");
   end

   logic            active;
   cls_e            mode;
   logic [NREG-1:0] mask;
   logic            base_pend;
   logic            nop_pend;
   logic            step;
   logic [RW-1:0]   rt_q;
   logic [RW-1:0]   rs_q;

   logic [NREG-1:0] pick_oh;
   logic [RW-1:0]   pick_idx;
   logic            pick_any;
   logic            pick_single;
   logic            wt_zero;
   logic            accept;
   cls_e            in_cls;
   logic [CW-1:0]   wait_val;
   logic            is_multi_in;

   kind_e           cur_kind;
   logic [RW-1:0]   cur_reg;
   logic            cur_last;

   uop_lowbit_pick #(.NREG(NREG)) pick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask   (mask),
      .onehot (pick_oh),
      .idx    (pick_idx),
      .any    (pick_any),
      .single (pick_single)
   );

   assign in_cls      = decode_cls(in_class);
   assign is_multi_in = (in_cls == CLS_LDM) || (in_cls == CLS_STM);

   always_comb begin
      case (in_cls)
         CLS_DIV:  wait_val = CW'(DIV_WAIT);
         CLS_MULS: wait_val = CW'(MUL_WAIT);
         default:  wait_val = '0;
      endcase
   end

   uop_wait_timer #(.CW(CW)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (wait_val),
      .zero     (wt_zero)
   );

   always_comb begin
      cur_kind = K_DATA;
      cur_reg  = rt_q;
      cur_last = 1'b1;
      case (mode)
         CLS_LDM, CLS_STM: begin
            if (nop_pend) begin
               cur_kind = K_NOP;
               cur_reg  = '0;
            end else if (pick_any) begin
               cur_reg  = pick_idx;
               cur_last = pick_single && !base_pend;
            end else begin
               cur_kind = K_BASE;
               cur_reg  = rs_q;
            end
         end
         CLS_LDD, CLS_STD, CLS_MOVD: begin
            cur_reg  = {rt_q[RW-1:1], step};
            cur_last = step;
         end
         CLS_LDPI: begin
            cur_kind = step ? K_BASE : K_DATA;
            cur_reg  = step ? rs_q : rt_q;
            cur_last = step;
         end
         CLS_STRR, CLS_MAC: begin
            cur_kind = step ? K_DATA : K_EXEC;
            cur_reg  = step ? rt_q : rs_q;
            cur_last = step;
         end
         CLS_DIV: begin
            cur_reg  = step ? rs_q : rt_q;
            cur_last = step;
         end
         CLS_MULS: begin
            cur_kind = K_EXEC;
         end
         default: ;
      endcase
   end

   assign uop_valid = active && wt_zero;
   assign uop_reg   = cur_reg;
   assign uop_kind  = cur_kind;
   assign uop_last  = uop_valid && cur_last;
   assign busy      = active;
   assign in_ready  = !active || (uop_valid && cur_last);
   assign accept    = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         mode      <= CLS_SINGLE;
         mask      <= '0;
         base_pend <= 1'b0;
         nop_pend  <= 1'b0;
         step      <= 1'b0;
         rt_q      <= '0;
         rs_q      <= '0;
      end else if (accept) begin
         active    <= 1'b1;
         mode      <= in_cls;
         mask      <= is_multi_in ? in_reglist : '0;
         base_pend <= is_multi_in && in_wb && (in_reglist != '0);
         nop_pend  <= is_multi_in && (in_reglist == '0);
         step      <= 1'b0;
         rt_q      <= in_rt;
         rs_q      <= in_rs;
      end else if (uop_valid) begin
         if (cur_last) begin
            active <= 1'b0;
         end else begin
            step <= 1'b1;
            if (pick_any) mask <= mask & ~pick_oh;
         end
      end
   end

   // R2
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_ready) |-> (uop_valid && uop_last));

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_last && !in_valid) |=> !busy);

   // R3
   ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_last && uop_kind == K_DATA &&
       (mode == CLS_LDM || mode == CLS_STM))
      |=> (uop_valid && (uop_kind != K_DATA || uop_reg > $past(uop_reg))));

   // R6
   pair_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_last &&
       (mode == CLS_LDD || mode == CLS_STD || mode == CLS_MOVD)) |-> uop_reg[0]);

   // R10
   stall_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !uop_valid) |-> !in_ready);

endmodule

// File: tb/uop_sequencer_tb_top.sv
module uop_sequencer_tb_top;

   localparam int NREG = 32;
   localparam int RW   = 5;
   localparam int DW   = 36;
   localparam int MW   = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            in_ready;
   logic [3:0]      in_class;
   logic [RW-1:0]   in_rt;
   logic [RW-1:0]   in_rs;
   logic [NREG-1:0] in_reglist;
   logic            in_wb;
   logic            uop_valid;
   logic [RW-1:0]   uop_reg;
   logic [1:0]      uop_kind;
   logic            uop_last;
   logic            busy;

   always #5 clk = ~clk;

   uop_sequencer #(.NREG(NREG), .DIV_WAIT(DW), .MUL_WAIT(MW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_class(in_class), .in_rt(in_rt), .in_rs(in_rs),
      .in_reglist(in_reglist), .in_wb(in_wb), .uop_valid(uop_valid),
      .uop_reg(uop_reg), .uop_kind(uop_kind), .uop_last(uop_last),
      .busy(busy)
   );

   typedef struct packed {
      logic          v;
      logic [RW-1:0] r;
      logic [1:0]    k;
      logic          l;
   } ent_t;

   ent_t  q[$];
   string qt[$];
   int    total = 0;
   int    bad   = 0;
   bit    acc;

   task automatic push(input logic v, input logic [RW-1:0] r,
                       input logic [1:0] k, input logic l, input string t);
      ent_t e;
      e.v = v; e.r = r; e.k = k; e.l = l;
      q.push_back(e);
      qt.push_back(t);
   endtask

   task automatic build(input logic [3:0] c, input logic [RW-1:0] rt,
                        input logic [RW-1:0] rs, input logic [NREG-1:0] lst,
                        input logic wb);
      int n;
      case (c)
         4'd1, 4'd2: begin
            n = 0;
            for (int i = 0; i < NREG; i++) begin
               if (lst[i]) begin
                  push(1, RW'(i), 2'd1, 0, "R3");
                  n++;
               end
            end
            if (n == 0)  push(1, 0, 2'd0, 1, "R5");
            else if (wb) push(1, rs, 2'd2, 1, "R4");
            else         q[q.size()-1].l = 1'b1;
         end
         4'd3, 4'd4, 4'd5: begin
            push(1, {rt[RW-1:1], 1'b0}, 2'd1, 0, "R6");
            push(1, {rt[RW-1:1], 1'b1}, 2'd1, 1, "R6");
         end
         4'd6: begin
            push(1, rt, 2'd1, 0, "R7");
            push(1, rs, 2'd2, 1, "R7");
         end
         4'd7: begin
            push(1, rs, 2'd3, 0, "R8");
            push(1, rt, 2'd1, 1, "R8");
         end
         4'd8: begin
            push(1, rs, 2'd3, 0, "R9");
            push(1, rt, 2'd1, 1, "R9");
         end
         4'd9: begin
            for (int i = 0; i < DW; i++) push(0, 0, 0, 0, "R10");
            push(1, rt, 2'd1, 0, "R10");
            push(1, rs, 2'd1, 1, "R10");
         end
         4'd10: begin
            for (int i = 0; i < MW; i++) push(0, 0, 0, 0, "R11");
            push(1, rt, 2'd3, 1, "R11");
         end
         default: push(1, rt, 2'd1, 1, "R12");
      endcase
   endtask

   task automatic cycle();
      logic  eb, er, ev;
      ent_t  e;
      string t;
      bit    ok;
      e  = '0;
      t  = "R2";
      eb = (q.size() != 0);
      if (eb) begin
         e = q[0];
         t = qt[0];
      end
      ev = eb && e.v;
      er = !eb || (q.size() == 1 && e.v);
      ok = (busy === eb) && (in_ready === er) && (uop_valid === ev);
      if (ev) ok = ok && (uop_reg === e.r) && (uop_kind === e.k) && (uop_last === e.l);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got busy=%0b rdy=%0b v=%0b reg=%0d kind=%0d last=%0b exp busy=%0b rdy=%0b v=%0b reg=%0d kind=%0d last=%0b",
                  t, busy, in_ready, uop_valid, uop_reg, uop_kind, uop_last,
                  eb, er, ev, e.r, e.k, e.l);
      end
      acc = in_valid && er;
      if (eb) begin
         void'(q.pop_front());
         void'(qt.pop_front());
      end
      if (acc) build(in_class, in_rt, in_rs, in_reglist, in_wb);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic issue(input logic [3:0] c, input logic [RW-1:0] rt,
                        input logic [RW-1:0] rs, input logic [NREG-1:0] lst,
                        input logic wb);
      in_valid   = 1'b1;
      in_class   = c;
      in_rt      = rt;
      in_rs      = rs;
      in_reglist = lst;
      in_wb      = wb;
      acc        = 1'b0;
      while (!acc) cycle();
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      for (int i = 0; i < n; i++) cycle();
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_class = '0; in_rt = '0; in_rs = '0;
      in_reglist = '0; in_wb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      total++;
      if (busy !== 1'b0 || uop_valid !== 1'b0 || in_ready !== 1'b1) begin
         bad++;
         $display("FAIL R1: got busy=%0b v=%0b rdy=%0b exp 0 0 1", busy, uop_valid, in_ready);
      end
      idle(2);
      issue(4'd0, 5'd9, 5'd1, '0, 0);                   // R12 single
      issue(4'd1, 5'd0, 5'd4, 32'h0000_0025, 0);        // R3 sparse list
      issue(4'd2, 5'd0, 5'd13, 32'h8000_0001, 1);       // R4 end bits + base
      idle(1);
      issue(4'd1, 5'd0, 5'd2, 32'hFFFF_FFFF, 1);        // R3 R4 full list
      issue(4'd2, 5'd0, 5'd6, 32'h0000_0000, 1);        // R5 empty with wb
      issue(4'd1, 5'd0, 5'd6, 32'h0000_0000, 0);        // R5 empty
      issue(4'd3, 5'd7, 5'd0, '0, 0);                   // R6 odd rt
      issue(4'd4, 5'd10, 5'd0, '0, 0);                  // R6 even rt
      issue(4'd5, 5'd3, 5'd0, '0, 1);                   // R6 move
      issue(4'd6, 5'd11, 5'd20, '0, 0);                 // R7
      issue(4'd7, 5'd12, 5'd21, '0, 0);                 // R8
      issue(4'd8, 5'd14, 5'd22, '0, 0);                 // R9
      issue(4'd9, 5'd15, 5'd23, '0, 0);                 // R10
      issue(4'd10, 5'd16, 5'd24, '0, 0);                // R11
      issue(4'd13, 5'd17, 5'd25, 32'h0000_00FF, 1);     // R12 undefined code
      issue(4'd1, 5'd0, 5'd30, 32'h0001_0010, 0);       // R3 after R12
      idle(3);
      issue(4'd9, 5'd1, 5'd2, '0, 0);                   // R10 from idle
      idle(DW + 6);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule